// File: doc/BRIEF.md
# MSI message write decoder

This block terminates a write-only address window that PCI functions target with their message-signalled interrupt writes. It accepts both message styles through one path. For MSI-X, each vector has its own message address and the data word is zero. For plain MSI, every vector shares one message address and the data word carries the vector number. Every write becomes a one-clock pulse on a global interrupt number, which goes to the interrupt controller.

The window is divided into one 64 KiB region per allocation-table entry. The offset bits above bit 15 select the entry. Offset bits 15..2 give a word-granular vector, which is ORed with the low data bits. The entry is looked up through a request/response port to an external allocation table. That table returns, in the same cycle, the entry's base interrupt number and a flag saying whether the entry is in use. The pulse carries base plus vector. Reads of the window have no defined result and are not decoded. Data arrives as a little-endian word, so data bit 0 is the least significant bit of the lowest byte.

Top module: `msi_wr_decoder`

## Requirements
- R1: After reset, `irq_valid_o` and `lkp_req_o` are low, and they stay low until a write is presented.
- R2: For a write presented in cycle t whose entry field, window offset bits [WIN_AW-1:16], is below NUM_ENTRIES, `lkp_req_o` is high in cycle t+1 with `lkp_idx_o` equal to that field.
- R3: The vector is window offset bits [15:2] ORed with data bits [13:0]. Offset bits [1:0] and data bits [DATA_W-1:14] have no effect on the result.
- R4: `irq_num_o` equals the base returned on `lkp_base_i` plus the vector, modulo 2^IRQ_W.
- R5: A write presented in cycle t with a used entry produces `irq_valid_o` high in cycle t+2 only. The pulse is one clock wide, never a held level.
- R6: A write whose entry field is NUM_ENTRIES or more raises neither `lkp_req_o` nor `irq_valid_o`.
- R7: A write to an entry whose `lkp_used_i` is low in the lookup cycle raises no pulse.
- R8: An MSI-X style write (offset = entry<<16 | i<<2, data 0) and an MSI style write (offset = entry<<16, data i) to the same entry both yield base+i.
- R9: Writes on consecutive cycles produce pulses on consecutive cycles, in write order, each with its own interrupt number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Window write strobe, one write per cycle |
| wr_addr_i | input | WIN_AW | Byte offset of the write inside the window |
| wr_data_i | input | DATA_W | Message data, little-endian |
| lkp_req_o | output | 1 | Allocation table lookup request |
| lkp_idx_o | output | $clog2(NUM_ENTRIES) | Entry index being looked up |
| lkp_base_i | input | IRQ_W | Base interrupt number of the looked-up entry (same cycle) |
| lkp_used_i | input | 1 | Looked-up entry holds an allocation |
| irq_valid_o | output | 1 | One-cycle interrupt pulse |
| irq_num_o | output | IRQ_W | Global interrupt number of the pulse |

## Verification
The lookup request is due one cycle after the write and the pulse two cycles after it. A lone write's pulse must be gone again in the third cycle. The bench drives each write on a falling edge. It samples the lookup port on the next falling edge, the pulse on the one after that, and checks that the pulse is low on the following one. Dropped writes are checked at the same sample points, so a missing request or pulse is seen exactly where a wrong design would show it. The back-to-back case samples three consecutive pulse cycles in order.

// File: rtl/msi_dec_pkg.sv
package msi_dec_pkg;
  localparam int unsigned REGION_LSB = 16;  // 64 KiB per entry
  localparam int unsigned WORD_LSB   = 2;   // vectors are word spaced
  localparam int unsigned VEC_W      = REGION_LSB - WORD_LSB;

  function automatic logic [VEC_W-1:0] merge_vector(
      input logic [REGION_LSB-1:0] off,
      input logic [VEC_W-1:0]      dat);
    return off[REGION_LSB-1:WORD_LSB] | dat;
  endfunction
endpackage

// File: rtl/msi_addr_split.sv
module msi_addr_split
  import msi_dec_pkg::*;
#(
  parameter int unsigned WIN_AW      = 20,
  parameter int unsigned NUM_ENTRIES = 6,
  parameter int unsigned IDX_W       = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_valid_i,
  input  logic [WIN_AW-1:0]     wr_addr_i,
  input  logic [VEC_W-1:0]      wr_data_lo_i,
  output logic                  req_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic [VEC_W-1:0]      vec_o
);
  localparam int unsigned FLD_W = WIN_AW - REGION_LSB;

  logic [FLD_W-1:0] fld;
  logic             in_range;
  logic             req_q;
  logic [IDX_W-1:0] idx_q;
  logic [VEC_W-1:0] vec_q;

  assign fld = wr_addr_i[WIN_AW-1:REGION_LSB];

  // full window decode needs no compare
  generate
    if (NUM_ENTRIES == (1 << FLD_W)) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_cmp
      assign in_range = (32'(fld) < NUM_ENTRIES);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      idx_q <= '0;
      vec_q <= '0;
    end else begin
      req_q <= wr_valid_i & in_range;
      if (wr_valid_i) begin
        idx_q <= fld[IDX_W-1:0];
        vec_q <= merge_vector(wr_addr_i[REGION_LSB-1:0], wr_data_lo_i);
      end
    end
  end

  assign req_o = req_q;
  assign idx_o = idx_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/msi_irq_sum.sv
module msi_irq_sum
  import msi_dec_pkg::*;
#(
  parameter int unsigned IRQ_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [IRQ_W-1:0] base_i,
  input  logic             used_i,
  output logic             pulse_o,
  output logic [IRQ_W-1:0] num_o
);
  logic             pulse_q;
  logic [IRQ_W-1:0] num_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      num_q   <= '0;
    end else begin
      pulse_q <= req_i & used_i;
      if (req_i) num_q <= base_i + IRQ_W'(vec_i);
    end
  end

  assign pulse_o = pulse_q;
  assign num_o   = num_q;
endmodule

// File: rtl/msi_wr_decoder.sv
module msi_wr_decoder
  import msi_dec_pkg::*;
#(
  parameter int unsigned WIN_AW      = 20,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_ENTRIES = 6,
  parameter int unsigned IRQ_W       = 16,
  localparam int unsigned IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [WIN_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              lkp_req_o,
  output logic [IDX_W-1:0]  lkp_idx_o,
  input  logic [IRQ_W-1:0]  lkp_base_i,
  input  logic              lkp_used_i,
  output logic              irq_valid_o,
  output logic [IRQ_W-1:0]  irq_num_o
);
  logic             s1_req;
  logic [VEC_W-1:0] s1_vec;

  msi_addr_split #(
    .WIN_AW      (WIN_AW),
    .NUM_ENTRIES (NUM_ENTRIES),
    .IDX_W       (IDX_W)
  ) u_split (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_valid_i   (wr_valid_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_lo_i (wr_data_i[VEC_W-1:0]),
    .req_o        (s1_req),
    .idx_o        (lkp_idx_o),
    .vec_o        (s1_vec)
  );

  assign lkp_req_o = s1_req;

  msi_irq_sum #(
    .IRQ_W (IRQ_W)
  ) u_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (s1_req),
    .vec_i   (s1_vec),
    .base_i  (lkp_base_i),
    .used_i  (lkp_used_i),
    .pulse_o (irq_valid_o),
    .num_o   (irq_num_o)
  );
endmodule

// File: rtl/msi_wr_decoder_chk.sv
module msi_wr_decoder_chk
  import msi_dec_pkg::*;
#(
  parameter int unsigned WIN_AW      = 20,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_ENTRIES = 6,
  parameter int unsigned IRQ_W       = 16,
  parameter int unsigned IDX_W       = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic [WIN_AW-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              lkp_req_o,
  input logic [IDX_W-1:0]  lkp_idx_o,
  input logic [IRQ_W-1:0]  lkp_base_i,
  input logic              lkp_used_i,
  input logic              irq_valid_o,
  input logic [IRQ_W-1:0]  irq_num_o
);
  logic [IRQ_W-1:0] exp_vec;
  assign exp_vec = IRQ_W'(wr_addr_i[REGION_LSB-1:WORD_LSB] | wr_data_i[VEC_W-1:0]);

  // R2: a request only follows a write
  a_r2_req_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_req_o |-> $past(wr_valid_i));

  // R6: requested index is inside the table
  a_r6_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_req_o |-> (32'(lkp_idx_o) < NUM_ENTRIES));

  // R5/R7: pulse only after a lookup of a used entry
  a_r7_pulse_needs_used: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> ($past(lkp_req_o) && $past(lkp_used_i)));

  // R1: idle input keeps lookup idle
  a_r1_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> !lkp_req_o);

  // R4: interrupt number is base plus merged vector
  a_r4_num_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (irq_num_o == IRQ_W'($past(lkp_base_i) + $past(exp_vec, 2))));
endmodule

bind msi_wr_decoder msi_wr_decoder_chk #(
  .WIN_AW      (WIN_AW),
  .DATA_W      (DATA_W),
  .NUM_ENTRIES (NUM_ENTRIES),
  .IRQ_W       (IRQ_W),
  .IDX_W       (IDX_W)
) u_chk (.*);

// File: tb/msi_wr_decoder_tb.sv
`timescale 1ns/1ps
module msi_wr_decoder_tb;
  localparam int unsigned WIN_AW = 20;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NENT   = 6;
  localparam int unsigned IRQ_W  = 16;
  localparam int unsigned IDX_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_valid = 1'b0;
  logic [WIN_AW-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              lkp_req;
  logic [IDX_W-1:0]  lkp_idx;
  logic [IRQ_W-1:0]  lkp_base;
  logic              lkp_used;
  logic              irq_valid;
  logic [IRQ_W-1:0]  irq_num;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [IRQ_W-1:0] tbl_base [8];
  logic             tbl_used [8];

  always #10 clk = ~clk;

  assign lkp_base = tbl_base[lkp_idx];
  assign lkp_used = tbl_used[lkp_idx];

  msi_wr_decoder #(
    .WIN_AW (WIN_AW), .DATA_W (DATA_W), .NUM_ENTRIES (NENT), .IRQ_W (IRQ_W)
  ) u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .wr_valid_i (wr_valid), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
    .lkp_req_o (lkp_req), .lkp_idx_o (lkp_idx),
    .lkp_base_i (lkp_base), .lkp_used_i (lkp_used),
    .irq_valid_o (irq_valid), .irq_num_o (irq_num)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one write; checks lookup at t+1, pulse at t+2, quiet at t+3
  task automatic send(input string req, input logic [WIN_AW-1:0] a, input logic [DATA_W-1:0] d,
                      input bit exp_req, input logic [IDX_W-1:0] exp_idx,
                      input bit exp_pulse, input logic [IRQ_W-1:0] exp_num);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    check({req, " lookup req"}, 32'(lkp_req), 32'(exp_req));
    if (exp_req) check({req, " lookup idx"}, 32'(lkp_idx), 32'(exp_idx));
    @(negedge clk);
    check({req, " pulse"}, 32'(irq_valid), 32'(exp_pulse));
    if (exp_pulse) check({req, " irq num"}, 32'(irq_num), 32'(exp_num));
    @(negedge clk);
    check({req, " pulse width"}, 32'(irq_valid), 32'd0);
  endtask

  task automatic t_reset;
    check("R1 reset req", 32'(lkp_req), 32'd0);
    check("R1 reset pulse", 32'(irq_valid), 32'd0);
    repeat (3) @(negedge clk);
    check("R1 idle pulse", 32'(irq_valid), 32'd0);
  endtask

  task automatic t_msix_msi;
    send("R8 msix e1 v5", 20'h10014, 32'h0, 1'b1, 3'd1, 1'b1, 16'h0205);
    send("R8 msi e1 v5",  20'h10000, 32'h5, 1'b1, 3'd1, 1'b1, 16'h0205);
    send("R8 msi e4 v7",  20'h40000, 32'h7, 1'b1, 3'd4, 1'b1, 16'h1007);
  endtask

  task automatic t_merge;
    send("R3 or merge", 20'h0000C, 32'h14, 1'b1, 3'd0, 1'b1, 16'h0117);
    send("R3 low addr ignored", 20'h0000F, 32'h14, 1'b1, 3'd0, 1'b1, 16'h0117);
    send("R3 high data ignored", 20'h50003, 32'hABCD0001, 1'b1, 3'd5, 1'b1, 16'h2001);
  endtask

  task automatic t_sum;
    send("R4 wrap", 20'h30080, 32'h0, 1'b1, 3'd3, 1'b1, 16'h0010);
    send("R4 max vector", 20'h4FFFC, 32'h0, 1'b1, 3'd4, 1'b1, 16'h4FFF);
    send("R2 R5 entry0", 20'h00004, 32'h0, 1'b1, 3'd0, 1'b1, 16'h0101);
  endtask

  task automatic t_drops;
    send("R7 empty entry", 20'h20008, 32'h0, 1'b1, 3'd2, 1'b0, 16'h0);
    send("R6 index 6", 20'h60000, 32'h0, 1'b0, 3'd0, 1'b0, 16'h0);
    send("R6 index 15", 20'hF0008, 32'h1, 1'b0, 3'd0, 1'b0, 16'h0);
  endtask

  task automatic t_back2back;
    @(negedge clk); wr_valid = 1'b1; wr_addr = 20'h00004; wr_data = 32'h0;
    @(negedge clk); wr_addr = 20'h10000; wr_data = 32'h2;
    @(negedge clk); wr_addr = 20'h5000C; wr_data = 32'h0;
    check("R9 first pulse", 32'(irq_valid), 32'd1);
    check("R9 first num", 32'(irq_num), 32'h0101);
    @(negedge clk); wr_valid = 1'b0;
    check("R9 second pulse", 32'(irq_valid), 32'd1);
    check("R9 second num", 32'(irq_num), 32'h0202);
    @(negedge clk);
    check("R9 third pulse", 32'(irq_valid), 32'd1);
    check("R9 third num", 32'(irq_num), 32'h2003);
    @(negedge clk);
    check("R9 end", 32'(irq_valid), 32'd0);
  endtask

  initial begin
    tbl_base[0] = 16'h0100; tbl_used[0] = 1'b1;
    tbl_base[1] = 16'h0200; tbl_used[1] = 1'b1;
    tbl_base[2] = 16'h0300; tbl_used[2] = 1'b0;
    tbl_base[3] = 16'hFFF0; tbl_used[3] = 1'b1;
    tbl_base[4] = 16'h1000; tbl_used[4] = 1'b1;
    tbl_base[5] = 16'h2000; tbl_used[5] = 1'b1;
    tbl_base[6] = 16'h7000; tbl_used[6] = 1'b1;
    tbl_base[7] = 16'h7100; tbl_used[7] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_msix_msi();
    t_merge();
    t_sum();
    t_drops();
    t_back2back();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule